// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a 16-bit offset and a four-bit-shifted 16-bit segment base into a 20-bit physical address for a one-megabyte memory space. It keeps four segment bases (code, stack, data, extra) that a simple write port loads. The block picks which base to apply from a tag that names where the offset came from: the instruction pointer, a stack or frame pointer, a general pointer or index register, a direct displacement, or the destination of a string operation.

Each request strobe produces a registered address and a 2-bit code naming the segment used. Both outputs appear on the clock after the strobe and stay put until the next strobe. An override input can force a different segment for every tag except the string destination, which is always tied to the extra segment. Sums that pass the top of memory wrap around to the bottom.

Top module: `seg_addr_gen`

## Requirements
- R1: The address output equals the chosen segment value times 16 plus the offset, kept to 20 bits (for example segment FE00h with offset 0020h gives FE020h, and 4000h with 1000h gives 41000h).
- R2: A carry out of bit 19 is dropped: segment FFFFh with offset 0010h gives 00000h, and FFFFh with FFFFh gives 0FFEFh.
- R3: Tag 0 (instruction pointer) selects the code segment and reports segment code 2'b10 when no override is given.
- R4: Tags 1 (stack pointer) and 2 (frame pointer) select the stack segment and report code 2'b01 when no override is given.
- R5: Tags 3 (base pointer register), 4 (source index), 5 (destination index, non-string) and 6 (direct displacement) select the data segment and report code 2'b11 when no override is given.
- R6: Tag 7 (string destination) always selects the extra segment and reports code 2'b00, even when the override is enabled.
- R7: With the override enabled, tags 0 to 6 use the segment named by the override select (same 2-bit codes: 00 extra, 01 stack, 10 code, 11 data), and that code is reported.
- R8: The address and segment code update on the clock edge that samples a request and hold their values through every cycle without a request, including cycles that write a segment register.
- R9: Reset sets the code segment to FFFFh and the other three to 0000h, clears the address output to 00000h and sets the segment code to 2'b10; a first fetch with tag 0 and offset 0000h then gives FFFF0h.
- R10: A write with select code (same 2-bit codes) loads that segment register at the clock edge; a request sampled on that same edge still uses the previous value, and later requests use the new one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| seg_we | input | 1 | Segment register write strobe |
| seg_wsel | input | 2 | Segment to write (00 extra, 01 stack, 10 code, 11 data) |
| seg_wdata | input | 16 | Value to load into the selected segment |
| req | input | 1 | Address request strobe |
| req_off | input | 16 | Offset of the request |
| req_base | input | 3 | Tag naming the offset's source register |
| ovr_en | input | 1 | Segment override enable |
| ovr_sel | input | 2 | Segment forced by the override |
| addr_out | output | 20 | Registered physical address |
| seg_code | output | 2 | Registered code of the segment used |

## Verification
The bench drives sums that cross the 1 MB boundary; a design that kept the carry, or shifted the segment by the wrong amount, would put the address in the wrong place or flag a mismatch in the low nibble. It applies an override on a string destination, where a design that let the override win would report a segment other than extra. It writes a segment register in the same cycle as a request that uses it, where a bypassing design would return the new base too early, and it writes registers while idle, where a design that recomputed the address from live state would let the outputs drift between requests.

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     seg_we,
  input  logic [1:0]               seg_wsel,
  input  logic [SEG_W-1:0]         seg_wdata,
  input  logic                     req,
  input  logic [OFF_W-1:0]         req_off,
  input  logic [2:0]               req_base,
  input  logic                     ovr_en,
  input  logic [1:0]               ovr_sel,
  output logic [SEG_W+SHIFT-1:0]   addr_out,
  output logic [1:0]               seg_code
);
  localparam int ADDR_W = SEG_W + SHIFT;

  localparam logic [1:0] SG_EXTRA = 2'b00;
  localparam logic [1:0] SG_STACK = 2'b01;
  localparam logic [1:0] SG_CODE  = 2'b10;
  localparam logic [1:0] SG_DATA  = 2'b11;

  localparam logic [2:0] B_IP   = 3'd0;
  localparam logic [2:0] B_SP   = 3'd1;
  localparam logic [2:0] B_BP   = 3'd2;
  localparam logic [2:0] B_STRD = 3'd7;

  logic [SEG_W-1:0] seg_q [4];
  logic [1:0]       dflt_sel, use_sel;
  logic [ADDR_W-1:0] sum;

  for (genvar g = 0; g < 4; g++) begin : g_seg
    localparam logic [SEG_W-1:0] RST_V = (g == int'(SG_CODE)) ? '1 : '0;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 seg_q[g] <= RST_V;
      else if (seg_we && seg_wsel == 2'(g))       seg_q[g] <= seg_wdata;
    end
  end

  always_comb begin
    case (req_base)
      B_IP:        dflt_sel = SG_CODE;
      B_SP, B_BP:  dflt_sel = SG_STACK;
      B_STRD:      dflt_sel = SG_EXTRA;
      default:     dflt_sel = SG_DATA;
    endcase
  end

  assign use_sel = (ovr_en && req_base != B_STRD) ? ovr_sel : dflt_sel;
  assign sum     = {seg_q[use_sel], {SHIFT{1'b0}}} + ADDR_W'(req_off);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_out <= '0;
      seg_code <= SG_CODE;
    end else if (req) begin
      addr_out <= sum;
      seg_code <= use_sel;
    end
  end

  p_low_nibble_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> addr_out[SHIFT-1:0] == $past(req_off[SHIFT-1:0]));

  p_default_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ovr_en && req_base == B_IP) |=> seg_code == SG_CODE);

  p_default_stack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ovr_en && (req_base == B_SP || req_base == B_BP)) |=> seg_code == SG_STACK);

  p_string_extra_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req && req_base == B_STRD) |=> seg_code == SG_EXTRA);

  p_override_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req && ovr_en && req_base != B_STRD) |=> seg_code == $past(ovr_sel));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> ($stable(addr_out) && $stable(seg_code)));
endmodule

// File: tb/seg_addr_gen_tb.sv
module seg_addr_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        seg_we = 1'b0;
  logic [1:0]  seg_wsel = '0;
  logic [15:0] seg_wdata = '0;
  logic        req = 1'b0;
  logic [15:0] req_off = '0;
  logic [2:0]  req_base = '0;
  logic        ovr_en = 1'b0;
  logic [1:0]  ovr_sel = '0;
  logic [19:0] addr_out;
  logic [1:0]  seg_code;

  int n_run = 0;
  int n_fail = 0;
  logic [15:0] mseg [4];
  logic [21:0] expq [$];
  string       tagq [$];

  always #2.5 clk = ~clk;

  seg_addr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .seg_we(seg_we), .seg_wsel(seg_wsel),
    .seg_wdata(seg_wdata), .req(req), .req_off(req_off), .req_base(req_base),
    .ovr_en(ovr_en), .ovr_sel(ovr_sel), .addr_out(addr_out), .seg_code(seg_code)
  );

  function automatic logic [1:0] pick(input logic [2:0] b, input logic oe, input logic [1:0] os);
    logic [1:0] d;
    if (b == 3'd7) return 2'b00;
    if (oe) return os;
    case (b)
      3'd0: d = 2'b10;
      3'd1, 3'd2: d = 2'b01;
      default: d = 2'b11;
    endcase
    return d;
  endfunction

  task automatic check(input string r, input logic [21:0] act, input logic [21:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: code/addr got %0h/%05h expected %0h/%05h", r,
               act[21:20], act[19:0], exp[21:20], exp[19:0]);
    end
  endtask

  task automatic issue(input logic [2:0] b, input logic [15:0] off,
                       input logic oe, input logic [1:0] os, input string r);
    logic [1:0]  s;
    logic [19:0] a;
    @(negedge clk);
    s = pick(b, oe, os);
    a = {mseg[s], 4'h0} + {4'h0, off};
    expq.push_back({s, a});
    tagq.push_back(r);
    req = 1'b1; req_base = b; req_off = off; ovr_en = oe; ovr_sel = os;
    seg_we = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
    req = 1'b0; seg_we = 1'b0; ovr_en = 1'b0;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] v);
    @(negedge clk);
    req = 1'b0; seg_we = 1'b1; seg_wsel = sel; seg_wdata = v;
    mseg[sel] = v;
  endtask

  // monitor: a request sampled at a rising edge is checked at the next falling edge
  initial begin
    forever begin
      @(posedge clk);
      if (rst_n === 1'b1 && req === 1'b1) begin
        @(negedge clk);
        if (expq.size() == 0) begin
          n_run++; n_fail++;
          $display("FAIL R8: result with no expected item");
        end else begin
          check(tagq.pop_front(), {seg_code, addr_out}, expq.pop_front());
        end
      end
    end
  end

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #1000000;
    n_run++; n_fail++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [21:0] held;
    mseg[0] = 16'h0000; mseg[1] = 16'h0000; mseg[2] = 16'hFFFF; mseg[3] = 16'h0000;
    repeat (3) @(negedge clk);
    check("R9 reset outputs", {seg_code, addr_out}, {2'b10, 20'h00000});
    rst_n = 1'b1;
    @(negedge clk);

    issue(3'd0, 16'h0000, 1'b0, 2'b00, "R9 first fetch FFFF0");
    issue(3'd5, 16'h0123, 1'b0, 2'b00, "R9 data seg reset 0");
    idle();

    wr(2'b10, 16'hFE00);
    issue(3'd0, 16'h0020, 1'b0, 2'b00, "R1 R3 code FE00:0020");
    wr(2'b11, 16'h4000);
    issue(3'd3, 16'h1000, 1'b0, 2'b00, "R1 R5 data 4000:1000");
    issue(3'd4, 16'h0005, 1'b0, 2'b00, "R5 source index");
    issue(3'd5, 16'hABCD, 1'b0, 2'b00, "R5 dest index");
    issue(3'd6, 16'h0300, 1'b0, 2'b00, "R5 displacement");
    wr(2'b01, 16'h5000);
    issue(3'd2, 16'h0014, 1'b0, 2'b00, "R4 frame pointer");
    issue(3'd1, 16'hFFFE, 1'b0, 2'b00, "R4 stack pointer");
    wr(2'b00, 16'h7000);
    issue(3'd7, 16'h0010, 1'b0, 2'b00, "R6 string dest");
    issue(3'd7, 16'h0010, 1'b1, 2'b11, "R6 string dest ignores override");
    issue(3'd3, 16'h0042, 1'b1, 2'b00, "R7 override to extra");
    issue(3'd0, 16'h0100, 1'b1, 2'b01, "R7 override fetch to stack");
    issue(3'd2, 16'h0008, 1'b1, 2'b10, "R7 override frame to code");
    idle();

    wr(2'b10, 16'hFFFF);
    issue(3'd0, 16'h0010, 1'b0, 2'b00, "R2 wrap to 00000");
    issue(3'd0, 16'hFFFF, 1'b0, 2'b00, "R2 wrap to 0FFEF");
    idle();

    // R10: write and request on the same edge
    @(negedge clk);
    begin
      logic [19:0] a;
      a = {mseg[3], 4'h0} + 20'h00010;
      expq.push_back({2'b11, a});
      tagq.push_back("R10 same-edge write uses old value");
      req = 1'b1; req_base = 3'd3; req_off = 16'h0010; ovr_en = 1'b0;
      seg_we = 1'b1; seg_wsel = 2'b11; seg_wdata = 16'h9000;
      mseg[3] = 16'h9000;
    end
    issue(3'd3, 16'h0010, 1'b0, 2'b00, "R10 later request sees new value");
    idle();

    // R8: outputs hold while idle and across writes
    @(negedge clk);
    held = {seg_code, addr_out};
    wr(2'b11, 16'h1234);
    wr(2'b10, 16'h0000);
    idle();
    idle();
    check("R8 hold across writes", {seg_code, addr_out}, held);
    issue(3'd6, 16'h0001, 1'b0, 2'b00, "R8 update after hold");
    idle();
    idle();
    check("R8 hold after update", {seg_code, addr_out}, {2'b11, 20'h12341});

    repeat (3) @(negedge clk);
    if (expq.size() != 0) begin
      n_run++; n_fail++;
      $display("FAIL R8: %0d results missing, expected 0", expq.size());
    end
    finish_run();
  end
endmodule